// File: doc/BRIEF.md
# Recursive Butterfly Bitonic Sorter

This block sorts a vector of 2^LOG2N unsigned keys into ascending order. It is a network of identical compare-exchange cells. Each cell takes two keys and returns them as a (smaller, larger) pair, or as (larger, smaller) when the cell is set to descend. The cells are wired in the bitonic pattern. At each merge level a cell pairs key k with key k + 2^j, which is the same wiring a butterfly gives when it applies the cell across nested interleave levels and then feeds two half-size butterflies. Before the final merge, the two halves of every block are sorted in opposite directions, so each merge sees a bitonic sequence.

A parameter turns on a register after every merge level. In that mode a valid flag moves along with the data. The sorter accepts one vector per clock and returns the result a fixed number of cycles later. With the option off, the network is purely combinational, and the valid output is the valid input passed straight through.

Top module: `bitonic_butterfly_sorter`

## Requirements
- R1: Key i of each bus occupies bits [i*KEY_W +: KEY_W]. On the output bus, key 0 is the smallest and key 2^LOG2N-1 the largest, so the output is non-decreasing with index.
- R2: Every input made only of the key values 0 and 1 comes out with all zeros at the low indices and all ones at the high indices.
- R3: For arbitrary multi-bit keys, the output is the ascending sort of the input: the same multiset of values, in non-decreasing order.
- R4: Equal keys are never exchanged. An input whose keys are all equal appears unchanged at the output, and duplicated values keep their multiplicity.
- R5: With PIPE=1, a vector presented with in_valid high produces out_valid high exactly LOG2N*(LOG2N+1)/2 clock cycles later, carrying that vector's sorted keys. Back-to-back vectors come out on back-to-back cycles.
- R6: While rst_n is low, and afterwards until a valid vector has crossed the pipeline, out_valid is low.
- R7: An input that is already ascending comes out unchanged. A strictly descending input comes out fully reversed.
- R8: Keys are compared as unsigned numbers, so a key with its top bit set orders above every key with that bit clear, and the all-ones key orders last.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the level registers |
| rst_n | input | 1 | Active-low synchronous reset of the valid flags |
| in_valid | input | 1 | Marks in_keys as a vector to sort |
| in_keys | input | 2^LOG2N*KEY_W | Unsorted keys, key i at bits [i*KEY_W +: KEY_W] |
| out_valid | output | 1 | Marks out_keys as a sorted result |
| out_keys | output | 2^LOG2N*KEY_W | Sorted keys, ascending with index |

## Verification
The bench streams every one of the 65536 zero-one vectors for 16 keys. A cell that picks the wrong direction at one merge level, or that is wired to the wrong partner, leaves some zero above a one for at least one of these vectors. Random keys include extremes with the top bit set, which catches a comparator that treats keys as signed or truncates them. Constant and heavily duplicated vectors catch a cell that exchanges equal keys or drops a value. A single isolated valid pulse checks that out_valid rises on exactly the predicted cycle and holds for just one cycle, so a level register that is missing or duplicated is visible as a shift in timing.

// File: rtl/bitonic_butterfly_sorter.sv
module bitonic_butterfly_sorter #(
  parameter int LOG2N = 4,
  parameter int KEY_W = 8,
  parameter bit PIPE  = 1'b1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  input  logic [(1<<LOG2N)*KEY_W-1:0]    in_keys,
  output logic                           out_valid,
  output logic [(1<<LOG2N)*KEY_W-1:0]    out_keys
);
  localparam int NKEYS  = 1 << LOG2N;
  localparam int LEVELS = LOG2N * (LOG2N + 1) / 2;
  localparam int BUS_W  = NKEYS * KEY_W;
  localparam int SUM_W  = KEY_W + LOG2N;

  logic [BUS_W-1:0] lv  [0:LEVELS];
  logic [BUS_W-1:0] nxt [0:LEVELS-1];
  logic [LEVELS:0]  vld;

  assign lv[0]     = in_keys;
  assign vld[0]    = in_valid;
  assign out_keys  = lv[LEVELS];
  assign out_valid = vld[LEVELS];

  function automatic logic [SUM_W-1:0] bus_sum(input logic [BUS_W-1:0] b);
    logic [SUM_W-1:0] s;
    s = '0;
    for (int i = 0; i < NKEYS; i++) s = s + SUM_W'(b[i*KEY_W +: KEY_W]);
    return s;
  endfunction

  for (genvar p = 1; p <= LOG2N; p++) begin : g_phase
    for (genvar j = p - 1; j >= 0; j--) begin : g_level
      localparam int S = (p * (p - 1)) / 2 + (p - 1 - j);
      logic [BUS_W-1:0] cur, nx;
      assign cur = lv[S];
      always_comb begin
        nx = cur;
        for (int k = 0; k < NKEYS; k++) begin
          if (((k >> j) & 1) == 0) begin
            logic [KEY_W-1:0] a, b;
            logic desc, swap;
            a    = cur[k*KEY_W +: KEY_W];
            b    = cur[(k + (1 << j))*KEY_W +: KEY_W];
            desc = (p < LOG2N) && (((k >> p) & 1) == 1);
            swap = desc ? (a < b) : (a > b);
            nx[k*KEY_W +: KEY_W]              = swap ? b : a;
            nx[(k + (1 << j))*KEY_W +: KEY_W] = swap ? a : b;
          end
        end
      end
      assign nxt[S] = nx;

      if (PIPE) begin : g_chk_reg
        p_sum_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
          vld[S+1] |-> bus_sum(lv[S+1]) == $past(bus_sum(lv[S])));
        p_valid_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
          vld[S+1] == $past(vld[S]));
      end else begin : g_chk_comb
        p_sum_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
          bus_sum(lv[S+1]) == bus_sum(lv[S]));
      end
    end
  end

  if (PIPE) begin : g_pipe
    always_ff @(posedge clk) begin
      for (int s = 0; s < LEVELS; s++) lv[s+1] <= nxt[s];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) vld[LEVELS:1] <= '0;
      else        vld[LEVELS:1] <= vld[LEVELS-1:0];
    end
  end else begin : g_comb
    for (genvar s = 0; s < LEVELS; s++) begin : g_wire
      assign lv[s+1]  = nxt[s];
      assign vld[s+1] = vld[s];
    end
  end

  logic out_sorted;
  always_comb begin
    out_sorted = 1'b1;
    for (int i = 0; i + 1 < NKEYS; i++)
      if (out_keys[i*KEY_W +: KEY_W] > out_keys[(i+1)*KEY_W +: KEY_W]) out_sorted = 1'b0;
  end

  p_out_sorted_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_sorted);
  p_valid_known_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(out_valid));
endmodule

// File: tb/bitonic_butterfly_sorter_tb.sv
module bitonic_butterfly_sorter_tb;
  localparam int LOG2N = 4;
  localparam int KW    = 8;
  localparam int M     = 1 << LOG2N;
  localparam int BUS   = M * KW;
  localparam int LAT   = LOG2N * (LOG2N + 1) / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [BUS-1:0] in_keys = '0;
  logic out_valid;
  logic [BUS-1:0] out_keys;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [BUS-1:0] vecs [0:63];

  always #4 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  bitonic_butterfly_sorter #(.LOG2N(LOG2N), .KEY_W(KW), .PIPE(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_keys(in_keys),
    .out_valid(out_valid), .out_keys(out_keys));

  function automatic logic [BUS-1:0] ref_sort(input logic [BUS-1:0] v);
    int a [M];
    logic [BUS-1:0] r;
    for (int i = 0; i < M; i++) a[i] = int'(v[i*KW +: KW]);
    for (int i = 1; i < M; i++)
      for (int k = i; k > 0 && a[k-1] > a[k]; k--) begin
        int t = a[k]; a[k] = a[k-1]; a[k-1] = t;
      end
    for (int i = 0; i < M; i++) r[i*KW +: KW] = KW'(a[i]);
    return r;
  endfunction

  task automatic chk_bit(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s out_valid actual=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic chk_bus(input string req, input logic [BUS-1:0] got, input logic [BUS-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s out_keys actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic stream(input int n, input string req);
    for (int c = 0; c < n + LAT; c++) begin
      @(negedge clk);
      if (c >= LAT) begin
        chk_bit(req, out_valid, 1'b1);
        chk_bus(req, out_keys, ref_sort(vecs[c-LAT]));
      end
      if (c < n) begin in_valid = 1'b1; in_keys = vecs[c]; end
      else       begin in_valid = 1'b0; in_keys = '0; end
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_bit("R6 during reset", out_valid, 1'b0);
    rst_n = 1'b1;
    repeat (LAT + 2) @(posedge clk);
    @(negedge clk);
    chk_bit("R6 idle after reset", out_valid, 1'b0);
  endtask

  task automatic t_latency;
    logic [BUS-1:0] v;
    for (int i = 0; i < M; i++) v[i*KW +: KW] = KW'((i * 37 + 11) % 256);
    @(negedge clk);
    in_valid = 1'b1; in_keys = v;
    @(negedge clk);
    in_valid = 1'b0; in_keys = '0;
    repeat (LAT - 2) @(negedge clk);
    chk_bit("R5 not yet valid", out_valid, 1'b0);
    @(negedge clk);
    chk_bit("R5 valid at latency", out_valid, 1'b1);
    chk_bus("R5 data at latency", out_keys, ref_sort(v));
    @(negedge clk);
    chk_bit("R5 single-cycle valid", out_valid, 1'b0);
  endtask

  task automatic t_exhaustive;
    for (int c = 0; c < (1 << M) + LAT; c++) begin
      @(negedge clk);
      if (c >= LAT) begin
        int pat = c - LAT;
        int ones = $countones(pat[M-1:0]);
        logic [BUS-1:0] e;
        for (int i = 0; i < M; i++) e[i*KW +: KW] = (i >= M - ones) ? KW'(1) : KW'(0);
        chk_bus("R2 zero-one", out_keys, e);
      end
      if (c < (1 << M)) begin
        logic [BUS-1:0] v;
        for (int i = 0; i < M; i++) v[i*KW +: KW] = KW'((c >> i) & 1);
        in_valid = 1'b1; in_keys = v;
      end else begin
        in_valid = 1'b0; in_keys = '0;
      end
    end
  endtask

  task automatic t_orders;
    for (int i = 0; i < M; i++) begin
      vecs[0][i*KW +: KW] = KW'(i * 9);
      vecs[1][i*KW +: KW] = KW'(250 - i * 7);
      vecs[2][i*KW +: KW] = KW'(8'h5A);
      vecs[3][i*KW +: KW] = KW'((i % 3) * 40);
    end
    stream(4, "R7 R4 R1 ordered/reversed/equal/dup");
    @(negedge clk);
    in_valid = 1'b1; in_keys = vecs[2];
    @(negedge clk);
    in_valid = 1'b0;
    repeat (LAT - 1) @(negedge clk);
    chk_bus("R4 all-equal unchanged", out_keys, vecs[2]);
    in_keys = '0;
  endtask

  task automatic t_random;
    for (int r = 0; r < 40; r++) begin
      for (int n = 0; n < 64; n++)
        for (int i = 0; i < M; i++) begin
          int sel = $urandom_range(0, 9);
          vecs[n][i*KW +: KW] = (sel == 0) ? KW'(0) : (sel == 1) ? {KW{1'b1}} :
                                (sel == 2) ? {1'b1, {(KW-1){1'b0}}} :
                                (sel == 3) ? KW'($urandom_range(0, 3)) : KW'($urandom);
        end
      stream(64, "R3 R8 random");
    end
  endtask

  initial begin
    while (cycles < 190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234));
    t_reset();
    t_latency();
    t_orders();
    t_exhaustive();
    t_random();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule